// File: doc/BRIEF.md
# Standby Mode and Software Reset Control Register

This block is one byte-wide control register on the peripheral bus of a small microcontroller. Software uses it to put the chip into one of two low-power states. In sleep, the core clock may pause. In stop, everything halts. Software also uses it to choose whether output pins keep their driven levels or float while stopped, and to issue a software reset whose length is counted in instruction cycles.

The command bits act only at the moment they are written and are never stored. Reading them always returns fixed values. A wake-up input returns the block from either low-power state to the running state. The block produces only the mode request lines, the pin float enable, the reset pulse and a mode indication. Gating the clocks and controlling the oscillator are left to the logic that consumes these signals.

Top module: `stby_ctrl`

## Requirements
- R1: After `rst_n` is released, `mode_state` is 2'b00 (run), `sleep_req`, `stop_req`, `pin_hiz` and `soft_rst` are 0, and a read of address 0x08 returns 0x10.
- R2: A read at address 0x08 returns bit 5 as the stored float-select bit and bit 4 as 1. Bits 7, 6, 3, 2, 1 and 0 always read 0. A read at any other address returns 0x00.
- R3: A write to 0x08 in run mode with bit 7 = 1 and bit 4 = 1 enters stop from the next cycle: `mode_state` becomes 2'b10 and `stop_req` becomes 1. Writing 0 to bit 7 changes no mode.
- R4: A write to 0x08 in run mode with bit 6 = 1, bit 7 = 0 and bit 4 = 1 enters sleep from the next cycle: `mode_state` becomes 2'b01 and `sleep_req` becomes 1.
- R5: A write with both bit 7 and bit 6 set enters stop, not sleep. `sleep_req` and `stop_req` are never high together.
- R6: While in sleep or stop, `wake` high at a clock edge returns the block to run on the next cycle, and any bus write is ignored. In run, `wake` has no effect.
- R7: In run mode, every write to 0x08 with bit 4 = 1 stores bit 5 as the float-select bit. `pin_hiz` is 1 exactly while in stop mode with that bit set.
- R8: A write to 0x08 in run mode with bit 4 = 0 raises `soft_rst` from the next cycle. The remaining bits of that write are ignored and the float-select bit clears. `soft_rst` stays high until `insn_tick` has been seen high on 4 clock edges after it rose, and it falls in the cycle after the 4th such edge. A tick in the cycle of the write does not count.
- R9: While `soft_rst` is high, bus writes have no effect on the mode, the float-select bit or the reset count.
- R10: Writes to addresses other than 0x08 change no output and no readback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| insn_tick | input | 1 | One-cycle pulse per instruction cycle |
| wake | input | 1 | Wake-up event from interrupt or external source |
| sleep_req | output | 1 | Sleep mode active |
| stop_req | output | 1 | Stop mode active |
| pin_hiz | output | 1 | Output pins float |
| soft_rst | output | 1 | Software reset pulse |
| mode_state | output | 2 | 00 run, 01 sleep, 10 stop |

## Verification
On every cycle, the checker enforces the following:
- sleep and stop are never active together;
- the float enable appears only in stop;
- the fixed read-back bits hold their values;
- wake always leaves a low-power mode;
- a reset write always raises the reset line;
- the reset line cannot fall without a tick;
- the reset line never outlives its tick budget.

The bench's scenarios are needed to show that writes are ignored while in reset, in a low-power mode, or at a foreign address. They are also needed to show stop winning over sleep, a same-cycle tick not counting, and the float-select bit clearing at reset. A reference model checks all outputs on every clock.

// File: rtl/stby_pkg.sv
package stby_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned BIT_STP = 7;
    localparam int unsigned BIT_SLP = 6;
    localparam int unsigned BIT_SPL = 5;
    localparam int unsigned BIT_RST = 4;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_STOP  = 2'd2
    } mode_e;
endpackage

// File: rtl/stby_mode_fsm.sv
module stby_mode_fsm
    import stby_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_ok,
    input  logic  cmd_stop,
    input  logic  cmd_sleep,
    input  logic  cmd_spl,
    input  logic  rst_start,
    input  logic  wake,
    output mode_e mode_q,
    output logic  spl_q
);
    typedef struct packed {
        mode_e mode;
        logic  spl;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.mode != MODE_RUN) begin
            if (wake) st_d.mode = MODE_RUN;
        end else if (wr_ok) begin
            if (rst_start) begin
                st_d.spl = 1'b0;
            end else begin
                st_d.spl = cmd_spl;
                if (cmd_stop)       st_d.mode = MODE_STOP;
                else if (cmd_sleep) st_d.mode = MODE_SLEEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_RUN, spl: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign spl_q  = st_q.spl;
endmodule

// File: rtl/stby_rst_timer.sv
module stby_rst_timer #(
    parameter int unsigned RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int unsigned CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!t_q.act) begin
            if (start) begin
                t_d.act = 1'b1;
                t_d.cnt = '0;
            end
        end else if (tick) begin
            if (t_q.cnt == LAST) begin
                t_d.act = 1'b0;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign active = t_q.act;
endmodule

// File: rtl/stby_rd_mux.sv
module stby_rd_mux
    import stby_pkg::*;
(
    input  logic              sel,
    input  logic              spl,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[BIT_SPL] = spl;
            rdata[BIT_RST] = 1'b1;
        end
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 8,
    parameter int unsigned RST_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              insn_tick,
    input  logic              wake,
    output logic              sleep_req,
    output logic              stop_req,
    output logic              pin_hiz,
    output logic              soft_rst,
    output logic [1:0]        mode_state
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic  sel, wr_ok, rst_start, spl_q;
    mode_e mode_q;

    assign sel       = (bus_addr == MY_ADDR);
    assign wr_ok     = sel && bus_we && !soft_rst && (mode_q == MODE_RUN);
    assign rst_start = wr_ok && !bus_wdata[BIT_RST];

    stby_mode_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .cmd_stop (bus_wdata[BIT_STP]),
        .cmd_sleep(bus_wdata[BIT_SLP]),
        .cmd_spl  (bus_wdata[BIT_SPL]),
        .rst_start(rst_start),
        .wake     (wake),
        .mode_q   (mode_q),
        .spl_q    (spl_q)
    );

    stby_rst_timer #(.RST_CYC(RST_CYC)) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .tick  (insn_tick),
        .active(soft_rst)
    );

    stby_rd_mux i_rd (
        .sel  (sel),
        .spl  (spl_q),
        .rdata(bus_rdata)
    );

    assign sleep_req  = (mode_q == MODE_SLEEP);
    assign stop_req   = (mode_q == MODE_STOP);
    assign pin_hiz    = (mode_q == MODE_STOP) && spl_q;
    assign mode_state = mode_q;
endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 8,
    parameter int unsigned RST_CYC  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              insn_tick,
    input logic              wake,
    input logic              sleep_req,
    input logic              stop_req,
    input logic              pin_hiz,
    input logic              soft_rst,
    input logic [1:0]        mode_state
);
    logic [31:0] tick_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tick_seen <= '0;
        else if (!soft_rst)             tick_seen <= '0;
        else if (insn_tick)             tick_seen <= tick_seen + 1;
    end

    p_mode_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sleep_req && stop_req));

    p_hiz_in_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz |-> stop_req);

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(REG_ADDR)) |->
            (bus_rdata[7:6] == 2'b00 && bus_rdata[4] && bus_rdata[3:0] == 4'h0));

    p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != 2'b00 && wake) |=> (mode_state == 2'b00));

    p_rst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(REG_ADDR) && !bus_wdata[4]
         && !soft_rst && mode_state == 2'b00) |=> soft_rst);

    p_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !insn_tick) |=> soft_rst);

    p_rst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (tick_seen < RST_CYC));

    p_run_in_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_state == 2'b00));
endmodule

bind stby_ctrl stby_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .RST_CYC (RST_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .insn_tick (insn_tick),
    .wake      (wake),
    .sleep_req (sleep_req),
    .stop_req  (stop_req),
    .pin_hiz   (pin_hiz),
    .soft_rst  (soft_rst),
    .mode_state(mode_state)
);

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       insn_tick = 1'b0;
    logic       wake = 1'b0;
    logic       sleep_req, stop_req, pin_hiz, soft_rst;
    logic [1:0] mode_state;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string scen = "R1 reset";

    // reference model state
    int m_mode = 0;   // 0 run, 1 sleep, 2 stop
    int m_spl = 0;
    int m_rst = 0;
    int m_ticks = 0;

    always #2.5 clk = ~clk;

    stby_ctrl i_stby_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .insn_tick(insn_tick),
        .wake(wake), .sleep_req(sleep_req), .stop_req(stop_req),
        .pin_hiz(pin_hiz), .soft_rst(soft_rst), .mode_state(mode_state)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_spl = 0; m_rst = 0; m_ticks = 0;
        end else if (m_mode != 0) begin
            if (wake) m_mode = 0;
        end else if (m_rst != 0) begin
            if (insn_tick) begin
                m_ticks = m_ticks + 1;
                if (m_ticks == 4) begin m_rst = 0; m_ticks = 0; end
            end
        end else if (bus_we && bus_addr == 8'h08) begin
            if (!bus_wdata[4]) begin
                m_rst = 1; m_ticks = 0; m_spl = 0;
            end else begin
                m_spl = bus_wdata[5];
                if (bus_wdata[7])      m_mode = 2;
                else if (bus_wdata[6]) m_mode = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", tag, scen, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int exp_rd;
            exp_rd = (bus_addr == 8'h08) ? ((m_spl << 5) | 16) : 0;
            chk(mode_state == m_mode[1:0], "R3/R4 mode_state", mode_state, m_mode);
            chk(sleep_req == (m_mode == 1), "R4 sleep_req", sleep_req, m_mode == 1);
            chk(stop_req == (m_mode == 2), "R3 stop_req", stop_req, m_mode == 2);
            chk(pin_hiz == (m_mode == 2 && m_spl == 1), "R7 pin_hiz", pin_hiz,
                m_mode == 2 && m_spl == 1);
            chk(soft_rst == (m_rst != 0), "R8 soft_rst", soft_rst, m_rst);
            chk(bus_rdata == exp_rd[7:0], "R2 bus_rdata", bus_rdata, exp_rd);
        end
    end

    task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d,
                        input logic tk, input logic wk);
        @(posedge clk);
        #1;
        bus_addr = a; bus_we = we; bus_wdata = d; insn_tick = tk; wake = wk;
    endtask

    task automatic idle(input int n, input logic tk, input logic wk);
        for (int i = 0; i < n; i++) step(8'h08, 1'b0, 8'h00, tk, wk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        step(a, 1'b1, d, 1'b0, 1'b0);
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog [%s] actual=hung expected=finish", scen);
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        bus_addr = 8'h08;
        #12;
        // R1: reset state observed explicitly
        chk(bus_rdata == 8'h10 && mode_state == 2'b00 && !soft_rst && !pin_hiz,
            "R1 reset state", bus_rdata, 8'h10);
        rst_n = 1'b1;
        idle(2, 1'b0, 1'b0);

        scen = "R2 readback other addr";
        step(8'h09, 1'b0, 8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b0, 8'h00, 1'b0, 1'b0);

        scen = "R10 foreign write";
        wr(8'h03, 8'hE0);
        wr(8'h88, 8'hC0);
        wr(8'h07, 8'h20);
        idle(2, 1'b0, 1'b0);

        scen = "R7 spl set";
        wr(8'h08, 8'h3F);
        idle(1, 1'b0, 1'b0);

        scen = "R3 zero write no effect";
        wr(8'h08, 8'h30);
        idle(2, 1'b0, 1'b0);

        scen = "R3 stop hiz";
        wr(8'h08, 8'hB0);
        scen = "R6 write in stop ignored";
        wr(8'h08, 8'h10);
        wr(8'h08, 8'h00);
        idle(2, 1'b1, 1'b0);
        scen = "R6 wake from stop";
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b1);
        idle(2, 1'b0, 1'b0);

        scen = "R7 stop without float";
        wr(8'h08, 8'h90);
        idle(1, 1'b0, 1'b0);
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b1);
        idle(1, 1'b0, 1'b0);

        scen = "R4 sleep";
        wr(8'h08, 8'h70);
        idle(2, 1'b0, 1'b0);
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b1);
        idle(1, 1'b0, 1'b0);

        scen = "R5 stop over sleep";
        wr(8'h08, 8'hD0);
        idle(1, 1'b0, 1'b0);
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b1);

        scen = "R6 wake in run ignored";
        idle(3, 1'b0, 1'b1);
        idle(1, 1'b0, 1'b0);

        scen = "R8 soft reset";
        wr(8'h08, 8'h30);
        step(8'h08, 1'b1, 8'hE0, 1'b1, 1'b0);  // reset write, tick here not counted
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b0);
        idle(2, 1'b1, 1'b0);
        scen = "R9 write during reset";
        wr(8'h08, 8'hB0);
        wr(8'h08, 8'h00);
        idle(3, 1'b0, 1'b0);
        scen = "R8 last ticks";
        idle(1, 1'b1, 1'b0);
        idle(2, 1'b0, 1'b0);
        idle(1, 1'b1, 1'b0);
        idle(3, 1'b0, 1'b0);

        scen = "R8 back-to-back reset";
        wr(8'h08, 8'h00);
        idle(6, 1'b1, 1'b0);
        scen = "R3 after reset";
        wr(8'h08, 8'h90);
        idle(1, 1'b0, 1'b0);
        step(8'h08, 1'b0, 8'h00, 1'b0, 1'b1);
        idle(2, 1'b0, 1'b0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule